// File: doc/BRIEF.md
# Watchdog Timer

A free-running supervision counter that software must restart at regular intervals. The block is controlled through a single 32-bit read-write control word on a simple register bus (one write strobe with write data, and read data that always reflects the current word). When the counter is enabled and reaches the end of one of eight selectable intervals, a timeout occurs. A timeout can set an interrupt flag and drive the interrupt output. It can also flag a wake-up and emit a wake pulse if the chip is in power-down. If software does not restart the count within a further grace window, the block emits a one-cycle reset request.

Most control fields are write-protected. They change only during a write that arrives while the `unlock` input is high; the sequencing that raises `unlock` lives outside the block. The three cause flags are sticky: hardware sets them, and software clears each one by writing 1 to its position. While a debug halt is acknowledged, counting can be paused, or a control bit can let it run on.

Control word layout: bit 0 restart (self-clearing), bit 1 reset enable, bit 2 reset flag, bit 3 interrupt flag, bit 4 wake enable, bit 5 wake flag, bit 6 interrupt enable, bit 7 run, bits 10:8 interval select, bit 31 run-through-debug. All other bits read 0.

Top module: `wdog_timer`

## Requirements
- R1: After reset every bit of the control word is 0, and `irq`, `wake` and `rst_req` are low.
- R2: Bits 0, 4, 6, 7, 10:8 and 31 change only on a write with `unlock` high. A write with `unlock` low leaves them unchanged.
- R3: A write of 1 to bit 0 with `unlock` high clears the interval counter and the grace window on the next clock. Bit 0 reads 1 for exactly one cycle after that write and then reads 0. Writing 0 to bit 0 has no effect.
- R4: Bit 7 = 1 lets the counter run. Bit 7 = 0 holds the counter and the grace window at zero, so a later re-enable starts a full interval.
- R5: With interval select S, a timeout occurs after 2^(4+2·S) counting clocks. If bit 6 is 1 at that point, bit 3 is set, and `irq` is high while bits 3 and 6 are both 1.
- R6: Bits 2, 3 and 5 are cleared by writing 1 to them, regardless of `unlock`. Writing 0 to them leaves them unchanged, and a hardware set in the same cycle wins.
- R7: A timeout while bit 4 = 1 and `pwr_down` = 1 sets bit 5 and drives `wake` high for one cycle, in the same cycle as bit 5 becomes visible. With `pwr_down` low, neither happens.
- R8: After a timeout, if 1024 further counting clocks pass with no restart and no disable, and bit 1 = 1, then `rst_req` is high for exactly one cycle and bit 2 is set. With bit 1 = 0, neither happens.
- R9: With bit 31 = 0, counting (both the interval and the grace window) pauses while `dbg_ack` is high. With bit 31 = 1, `dbg_ack` has no effect.
- R10: Bit 1 is written by every write, with or without `unlock`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Counter and register clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe for the control word |
| wr_data | input | 32 | Write data |
| unlock | input | 1 | High to permit writes to protected fields |
| rd_data | output | 32 | Current control word |
| dbg_ack | input | 1 | Debug halt acknowledged |
| pwr_down | input | 1 | Chip is in power-down |
| irq | output | 1 | Interrupt request (flag and enable both set) |
| wake | output | 1 | One-cycle wake-up pulse |
| rst_req | output | 1 | One-cycle reset request |

## Verification
The bench measures the exact timeout edge for two interval selections and the exact reset edge after the grace window. A wrong exponent, an off-by-one limit, or an extra pipeline stage therefore shows up as a flag rising one edge early or late. The bench re-enables the counter after a disable, so a design that only pauses instead of clearing the counter times out a few cycles too soon. Restarts written with `unlock` low must still let the timeout occur, while unlocked restarts during a pending grace window must cancel the reset; a design that ignores the lock, or fails to clear the grace window, produces a stray `rst_req`. The debug-halt pause and its override, together with write-one-to-clear on flags that are already set, are also checked, because a design that inverts the override, or clears a flag on a written 0, changes the read-back word.

// File: rtl/wdog_pkg.sv
package wdog_pkg;

  typedef struct packed {
    logic       dbg_run;
    logic [2:0] sel;
    logic       run;
    logic       irq_en;
    logic       wake_flag;
    logic       wake_en;
    logic       irq_flag;
    logic       rst_flag;
    logic       rst_en;
    logic       restart;
  } ctl_t;

  // Map the control fields onto the 32-bit bus word.
  function automatic logic [31:0] pack_ctl(input ctl_t c);
    logic [31:0] w;
    w       = '0;
    w[0]    = c.restart;
    w[1]    = c.rst_en;
    w[2]    = c.rst_flag;
    w[3]    = c.irq_flag;
    w[4]    = c.wake_en;
    w[5]    = c.wake_flag;
    w[6]    = c.irq_en;
    w[7]    = c.run;
    w[10:8] = c.sel;
    w[31]   = c.dbg_run;
    return w;
  endfunction

  // Interval length in counting clocks: 2^(base + step*sel).
  function automatic int unsigned period_len(input logic [2:0] sel,
                                             input int unsigned base,
                                             input int unsigned step);
    return 32'd1 << (base + step * 32'(sel));
  endfunction

endpackage

// File: rtl/wdog_ctl_reg.sv
module wdog_ctl_reg
  import wdog_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        unlock,
  input  logic        set_irq,
  input  logic        set_rst,
  input  logic        set_wake,
  output ctl_t        ctl
);

  logic wr_open;
  assign wr_open = wr_en && unlock;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl <= '0;
    end else begin
      // restart request lives for a single cycle
      ctl.restart <= wr_open && wr_data[0];
      if (wr_en) ctl.rst_en <= wr_data[1];
      if (wr_open) begin
        ctl.wake_en <= wr_data[4];
        ctl.irq_en  <= wr_data[6];
        ctl.run     <= wr_data[7];
        ctl.sel     <= wr_data[10:8];
        ctl.dbg_run <= wr_data[31];
      end
      // sticky causes: hardware set dominates a write-one clear
      ctl.rst_flag  <= set_rst  || (ctl.rst_flag  && !(wr_en && wr_data[2]));
      ctl.irq_flag  <= set_irq  || (ctl.irq_flag  && !(wr_en && wr_data[3]));
      ctl.wake_flag <= set_wake || (ctl.wake_flag && !(wr_en && wr_data[5]));
    end
  end

  p_lock_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_open |=> $stable({ctl.dbg_run, ctl.sel, ctl.run, ctl.irq_en, ctl.wake_en}))
    else $error("p_lock_r2");

  p_sticky_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.irq_flag && !wr_en) |=> ctl.irq_flag)
    else $error("p_sticky_r6");

endmodule

// File: rtl/wdog_interval.sv
module wdog_interval
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_LOG = 4,
  parameter int unsigned STEP_LOG = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  input  logic       tick,
  input  logic       restart,
  input  logic [2:0] sel,
  output logic       timeout
);

  localparam int unsigned CNT_W = BASE_LOG + STEP_LOG * 7;

  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] last;
  logic             at_end;

  always_comb last = CNT_W'(period_len(sel, BASE_LOG, STEP_LOG) - 1);
  // >= keeps a shortened interval from running on to the counter's wrap
  assign at_end  = (cnt >= last);
  assign timeout = run && !restart && tick && at_end;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              cnt <= '0;
    else if (!run || restart) cnt <= '0;
    else if (tick)           cnt <= at_end ? '0 : cnt + 1'b1;
  end

  p_restart_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt == '0))
    else $error("p_restart_clears_r3");

  p_off_clears_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (cnt == '0))
    else $error("p_off_clears_r4");

  p_freeze_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (run && !tick && !restart) |=> $stable(cnt))
    else $error("p_freeze_r9");

  p_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    timeout |=> (cnt == '0))
    else $error("p_wrap_r5");

endmodule

// File: rtl/wdog_grace.sv
module wdog_grace #(
  parameter int unsigned GRACE_CLKS = 1024
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic restart,
  input  logic timeout,
  output logic expire
);

  localparam int unsigned G_W = (GRACE_CLKS > 1) ? $clog2(GRACE_CLKS) : 1;

  logic           armed;
  logic [G_W-1:0] gcnt;

  assign expire = armed && run && !restart && tick && (gcnt == G_W'(GRACE_CLKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      armed <= 1'b0;
      gcnt  <= '0;
    end else if (!run || restart || expire) begin
      armed <= 1'b0;
      gcnt  <= '0;
    end else if (timeout && !armed) begin
      armed <= 1'b1;
      gcnt  <= '0;
    end else if (armed && tick) begin
      gcnt  <= gcnt + 1'b1;
    end
  end

  p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> (gcnt == '0))
    else $error("p_idle_zero_r8");

  p_expire_once_r8: assert property (@(posedge clk) disable iff (!rst_n)
    expire |=> !armed)
    else $error("p_expire_once_r8");

endmodule

// File: rtl/wdog_timer.sv
module wdog_timer
  import wdog_pkg::*;
#(
  parameter int unsigned BASE_LOG   = 4,
  parameter int unsigned STEP_LOG   = 2,
  parameter int unsigned GRACE_CLKS = 1024
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [31:0] wr_data,
  input  logic        unlock,
  output logic [31:0] rd_data,
  input  logic        dbg_ack,
  input  logic        pwr_down,
  output logic        irq,
  output logic        wake,
  output logic        rst_req
);

  ctl_t ctl;
  logic tick;
  logic timeout;
  logic expire;
  logic set_irq;
  logic set_rst;
  logic set_wake;

  assign tick     = ctl.run && (!dbg_ack || ctl.dbg_run);
  assign set_irq  = timeout && ctl.irq_en;
  assign set_wake = timeout && ctl.wake_en && pwr_down;
  assign set_rst  = expire && ctl.rst_en;

  wdog_ctl_reg u_reg (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .unlock(unlock),
    .set_irq(set_irq), .set_rst(set_rst), .set_wake(set_wake), .ctl(ctl)
  );

  wdog_interval #(.BASE_LOG(BASE_LOG), .STEP_LOG(STEP_LOG)) u_int (
    .clk(clk), .rst_n(rst_n), .run(ctl.run), .tick(tick),
    .restart(ctl.restart), .sel(ctl.sel), .timeout(timeout)
  );

  wdog_grace #(.GRACE_CLKS(GRACE_CLKS)) u_grace (
    .clk(clk), .rst_n(rst_n), .run(ctl.run), .tick(tick),
    .restart(ctl.restart), .timeout(timeout), .expire(expire)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_req <= 1'b0;
      wake    <= 1'b0;
    end else begin
      rst_req <= set_rst;
      wake    <= set_wake;
    end
  end

  assign irq     = ctl.irq_flag && ctl.irq_en;
  assign rd_data = pack_ctl(ctl);

  p_if_set_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (timeout && ctl.irq_en) |=> ctl.irq_flag)
    else $error("p_if_set_r5");

  p_wake_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wake |-> ctl.wake_flag)
    else $error("p_wake_flag_r7");

  p_rst_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |=> !rst_req)
    else $error("p_rst_pulse_r8");

  p_rst_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl.rst_en |=> !rst_req)
    else $error("p_rst_gated_r8");

  p_rst_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rst_req |-> ctl.rst_flag)
    else $error("p_rst_flag_r8");

endmodule

// File: tb/tb_wdog_timer.sv
module tb_wdog_timer;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic        unlock = 1'b0;
  logic [31:0] rd_data;
  logic        dbg_ack = 1'b0;
  logic        pwr_down = 1'b0;
  logic        irq, wake, rst_req;

  int n_chk = 0;
  int n_err = 0;
  int rst_seen = 0;
  int wake_seen = 0;

  always #5 clk = ~clk;

  wdog_timer dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .unlock(unlock),
    .rd_data(rd_data), .dbg_ack(dbg_ack), .pwr_down(pwr_down),
    .irq(irq), .wake(wake), .rst_req(rst_req)
  );

  always @(posedge clk) begin
    if (rst_req) rst_seen++;
    if (wake)    wake_seen++;
  end

  // {unlock, write data, expected word afterwards}; applied in order
  localparam logic [64:0] VEC [5] = '{
    {1'b0, 32'hFFFF_FFFE, 32'h0000_0002},  // R2 R10: only bit 1 lands
    {1'b1, 32'h8000_0750, 32'h8000_0750},  // R2: unlocked protected write
    {1'b0, 32'h0000_0002, 32'h8000_0752},  // R2 R10: locked keeps fields
    {1'b1, 32'h0000_0000, 32'h0000_0000},
    {1'b1, 32'h0000_0300, 32'h0000_0300}
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  // called at a falling edge; returns at the falling edge after the write edge
  task automatic wr(input logic ul, input logic [31:0] d);
    wr_en = 1'b1; wr_data = d; unlock = ul;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0; unlock = 1'b0;
  endtask

  task automatic clear_all();
    wr(1'b1, 32'h0);
    wr(1'b0, 32'h2C);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 word in reset", rd_data, 32'h0);
    rst_n = 1'b1;
    step(1);
    check("R1 word after reset", rd_data, 32'h0);
    check("R1 outputs after reset", {29'd0, irq, wake, rst_req}, 32'h0);

    for (int i = 0; i < 5; i++) begin
      wr(VEC[i][64], VEC[i][63:32]);
      check($sformatf("R2 vector %0d", i), rd_data, VEC[i][31:0]);
    end
    clear_all();
    check("R6 cleared word", rd_data, 32'h0);

    // R5: shortest interval, 16 clocks
    wr(1'b1, 32'hC0);
    step(15); check("R5 no flag at 15", {31'd0, irq}, 32'h0);
    step(1);  check("R5 flag at 16", rd_data[3], 1'b1);
    check("R5 irq at 16", {31'd0, irq}, 32'h1);
    clear_all();

    // R5: select 1 gives 64 clocks
    wr(1'b1, 32'h1C0);
    step(63); check("R5 sel1 no flag at 63", rd_data[3], 1'b0);
    step(1);  check("R5 sel1 flag at 64", rd_data[3], 1'b1);
    clear_all();

    // R5: interrupt disabled, no flag
    wr(1'b1, 32'h80);
    step(20);
    check("R5 disabled flag", rd_data[3], 1'b0);
    check("R5 disabled irq", {31'd0, irq}, 32'h0);
    clear_all();

    // R7: wake in power-down
    pwr_down = 1'b1; wake_seen = 0;
    wr(1'b1, 32'hD0);
    step(15); check("R7 no wake at 15", {30'd0, wake, rd_data[5]}, 32'h0);
    step(1);  check("R7 wake at 16", {30'd0, wake, rd_data[5]}, 32'h3);
    step(1);  check("R7 wake one cycle", {31'd0, wake}, 32'h0);
    // R6: disable keeps flags, then clear one at a time
    wr(1'b1, 32'h0);
    check("R6 flags kept", rd_data, 32'h28);
    wr(1'b0, 32'h08);
    check("R6 clear irq flag only", rd_data, 32'h20);
    wr(1'b0, 32'h20);
    check("R6 clear wake flag", rd_data, 32'h0);
    pwr_down = 1'b0; wake_seen = 0;
    wr(1'b1, 32'hD0);
    step(20);
    check("R7 awake no flag", rd_data[5], 1'b0);
    check("R7 awake no pulse", wake_seen, 0);
    clear_all();

    // R8: reset after the grace window
    rst_seen = 0;
    wr(1'b1, 32'h82);
    step(1039); check("R8 no reset at 1039", {31'd0, rst_req}, 32'h0);
    step(1);    check("R8 reset at 1040", {30'd0, rst_req, rd_data[2]}, 32'h3);
    step(1);    check("R8 reset one cycle", {31'd0, rst_req}, 32'h0);
    wr(1'b1, 32'h0);
    wr(1'b0, 32'h04);
    check("R6 reset flag cleared", rd_data, 32'h0);

    // R8: reset disabled
    rst_seen = 0;
    wr(1'b1, 32'hC0);
    step(1100);
    check("R8 disabled no pulse", rst_seen, 0);
    check("R8 disabled no flag", rd_data[2], 1'b0);
    clear_all();

    // R3: locked restarts ignored
    wr(1'b1, 32'hC0);
    for (int i = 0; i < 5; i++) begin
      wr(1'b0, 32'h1);
      if (i == 0) check("R3 locked restart bit", rd_data[0], 1'b0);
      step(9);
    end
    check("R3 locked restart timeout", {31'd0, irq}, 32'h1);
    clear_all();

    // R3: unlocked restarts cancel a pending reset
    rst_seen = 0;
    wr(1'b1, 32'hC2);
    step(20);
    for (int i = 0; i < 100; i++) begin
      wr(1'b1, 32'hC3);
      if (i == 0) check("R3 restart bit set", rd_data[0], 1'b1);
      step(1);
      if (i == 0) check("R3 restart bit self-clears", rd_data[0], 1'b0);
      step(9);
    end
    check("R3 no reset while serviced", rst_seen, 0);
    clear_all();

    // R4: disable clears the count
    wr(1'b1, 32'hC0);
    step(10);
    wr(1'b1, 32'h40);
    wr(1'b1, 32'hC0);
    step(15); check("R4 full interval after re-enable", rd_data[3], 1'b0);
    step(1);  check("R4 timeout after re-enable", rd_data[3], 1'b1);
    clear_all();

    // R9: debug halt pause and override
    dbg_ack = 1'b1;
    wr(1'b1, 32'hC0);
    step(40); check("R9 paused", rd_data[3], 1'b0);
    dbg_ack = 1'b0;
    step(15); check("R9 resumed 15", rd_data[3], 1'b0);
    step(1);  check("R9 resumed 16", rd_data[3], 1'b1);
    clear_all();
    dbg_ack = 1'b1;
    wr(1'b1, 32'h8000_00C0);
    step(15); check("R9 override 15", rd_data[3], 1'b0);
    step(1);  check("R9 override 16", rd_data[3], 1'b1);
    dbg_ack = 1'b0;
    clear_all();

    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule